// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Hazard Unit

This block resolves read-after-write data hazards in a five-stage in-order pipeline. For each of the two source operands of the instruction in the execute stage, it picks the operand source: the register file, the result held in the EX/MEM register, or the result held in the MEM/WB register. Back-to-back dependent ALU instructions therefore run without a pause. The unit also spots the one case that forwarding cannot cover. When a load sits in ID/EX and the instruction in IF/ID reads its destination, the loaded data does not exist until after the memory stage. The unit then raises a stall that freezes the PC and IF/ID, and a bubble request that loads ID/EX with a nop whose control flags are cleared. This costs exactly one cycle. After that cycle the value arrives through MEM/WB forwarding.

A register file is included so that the hazard logic can be exercised against real operand values. The register file writes in the first half of a cycle and reads in the second half, so a read in the same cycle as a write-back returns the new value. Register 0 always reads zero. Write-after-read and write-after-write orderings need no action and get none.

Top module: `fwd_hazard_top`

## Requirements
- R1: For each operand, the select is EX/MEM (2'b10) when the EX/MEM instruction has its register-write flag set, its destination is nonzero and equals the ID/EX source, and it is not a load.
- R2: When R1 does not apply, the select is MEM/WB (2'b01) if the MEM/WB instruction has its register-write flag set, its destination is nonzero and it equals the source.
- R3: When both EX/MEM and MEM/WB qualify for the same source, the younger EX/MEM result wins (2'b10).
- R4: The select is the register file (2'b00) when no stage qualifies, including when a matching stage has its write flag clear or its destination is register 0.
- R5: A load held in EX/MEM is never chosen as a forwarding source. The select falls back to MEM/WB or to the register file.
- R6: When ID/EX holds a load with a nonzero destination that equals either IF/ID source, stall and bubble are both 1 in that same cycle.
- R7: Stall and bubble stay 0 when ID/EX is not a load, or when its destination is register 0 or matches neither IF/ID source. One stall cycle, followed by MEM/WB forwarding, is enough for a dependent instruction that follows a load.
- R8: A write with the write flag set to a nonzero register is stored at the clock edge and read back unchanged in later cycles.
- R9: A read of the register being written in the same cycle returns the write data.
- R10: Register 0 reads as zero, and writes to it are ignored.
- R11: Reset clears every register of the register file to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ifid_rs1 | input | 5 | First source index of the instruction in IF/ID (register file read address 1) |
| ifid_rs2 | input | 5 | Second source index of the instruction in IF/ID (register file read address 2) |
| idex_rs1 | input | 5 | First source index of the instruction in ID/EX |
| idex_rs2 | input | 5 | Second source index of the instruction in ID/EX |
| idex_rd | input | 5 | Destination index of the instruction in ID/EX |
| idex_memrd | input | 1 | ID/EX instruction is a load |
| exmem_rd | input | 5 | Destination index in EX/MEM |
| exmem_regwr | input | 1 | EX/MEM register-write flag |
| exmem_memrd | input | 1 | EX/MEM instruction is a load |
| memwb_rd | input | 5 | Destination index in MEM/WB (register file write address) |
| memwb_regwr | input | 1 | MEM/WB register-write flag (register file write enable) |
| memwb_data | input | 32 | Write-back data |
| fwd_a | output | 2 | Operand 1 source: 00 register file, 10 EX/MEM, 01 MEM/WB |
| fwd_b | output | 2 | Operand 2 source, same encoding |
| stall | output | 1 | Hold PC and IF/ID |
| bubble | output | 1 | Load a cleared nop into ID/EX |
| rf_rdata1 | output | 32 | Register file read data for ifid_rs1 |
| rf_rdata2 | output | 32 | Register file read data for ifid_rs2 |

## Verification
The bench targets the cases where two producers match one source, and checks that EX/MEM wins. A design with the priority reversed would hand the consumer a stale, older value. It drives matches on register 0 and matches with the write flag clear. A design that ignored either condition would forward junk from a store, a branch or the zero register. It walks a load through its stall cycle, its bubble cycle and its MEM/WB forward. A design without the load filter on EX/MEM would forward an address instead of data, and a design that stalled too long or too briefly would show up on the stall line. It also reads a register in the same cycle that it is written. A register file without that bypass returns the old value one cycle too long.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SRC_RF    = 2'b00,
    SRC_MEMWB = 2'b01,
    SRC_EXMEM = 2'b10
  } opnd_src_e;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] exmem_rd,
  input  logic          exmem_regwr,
  input  logic          exmem_memrd,
  input  logic [AW-1:0] memwb_rd,
  input  logic          memwb_regwr,
  output logic [1:0]    sel
);
  logic hit_exmem;
  logic hit_memwb;

  // A load in EX/MEM has no data yet, so it is never a forwarding source.
  assign hit_exmem = exmem_regwr && !exmem_memrd && (exmem_rd != '0) && (exmem_rd == src);
  assign hit_memwb = memwb_regwr && (memwb_rd != '0) && (memwb_rd == src);

  always_comb begin
    opnd_src_e s;
    if (hit_exmem)      s = SRC_EXMEM;
    else if (hit_memwb) s = SRC_MEMWB;
    else                s = SRC_RF;
    sel = s;
  end
endmodule

// File: rtl/hz_loaduse.sv
module hz_loaduse #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] ifid_rs1,
  input  logic [AW-1:0] ifid_rs2,
  input  logic [AW-1:0] idex_rd,
  input  logic          idex_memrd,
  output logic          stall,
  output logic          bubble
);
  logic dep;

  assign dep    = (idex_rd != '0) && ((idex_rd == ifid_rs1) || (idex_rd == ifid_rs2));
  assign stall  = idex_memrd && dep;
  assign bubble = stall;
endmodule

// File: rtl/hz_regfile.sv
module hz_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wen,
  input  logic [AW-1:0]   waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [AW-1:0]   raddr1,
  input  logic [AW-1:0]   raddr2,
  output logic [XLEN-1:0] rdata1,
  output logic [XLEN-1:0] rdata2
);
  logic [XLEN-1:0] regs_q [NREG];
  logic [NREG-1:0] we_vec;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign we_vec[i] = 1'b0;
      assign regs_q[i] = '0;
    end else begin : g_data
      always_comb we_vec[i] = wen && (waddr == AW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         regs_q[i] <= '0;
        else if (we_vec[i]) regs_q[i] <= wdata;
      end
    end
  end

  // The write lands in the first half of the cycle, so a same-cycle read sees it.
  function automatic logic [XLEN-1:0] read_port(input logic [AW-1:0] a);
    if (a == '0)                return '0;
    else if (wen && waddr == a) return wdata;
    else                        return regs_q[a];
  endfunction

  always_comb begin
    rdata1 = read_port(raddr1);
    rdata2 = read_port(raddr2);
  end
endmodule

// File: rtl/fwd_hazard_top.sv
module fwd_hazard_top #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   ifid_rs1,
  input  logic [AW-1:0]   ifid_rs2,
  input  logic [AW-1:0]   idex_rs1,
  input  logic [AW-1:0]   idex_rs2,
  input  logic [AW-1:0]   idex_rd,
  input  logic            idex_memrd,
  input  logic [AW-1:0]   exmem_rd,
  input  logic            exmem_regwr,
  input  logic            exmem_memrd,
  input  logic [AW-1:0]   memwb_rd,
  input  logic            memwb_regwr,
  input  logic [XLEN-1:0] memwb_data,
  output logic [1:0]      fwd_a,
  output logic [1:0]      fwd_b,
  output logic            stall,
  output logic            bubble,
  output logic [XLEN-1:0] rf_rdata1,
  output logic [XLEN-1:0] rf_rdata2
);
  localparam int NOPND = 2;

  logic [AW-1:0] srcs [NOPND];
  logic [1:0]    sels [NOPND];

  assign srcs[0] = idex_rs1;
  assign srcs[1] = idex_rs2;

  for (genvar k = 0; k < NOPND; k++) begin : g_opnd
    hz_fwd_sel #(.AW(AW)) u_sel (
      .src         (srcs[k]),
      .exmem_rd    (exmem_rd),
      .exmem_regwr (exmem_regwr),
      .exmem_memrd (exmem_memrd),
      .memwb_rd    (memwb_rd),
      .memwb_regwr (memwb_regwr),
      .sel         (sels[k])
    );
  end

  assign fwd_a = sels[0];
  assign fwd_b = sels[1];

  hz_loaduse #(.AW(AW)) u_lu (
    .ifid_rs1   (ifid_rs1),
    .ifid_rs2   (ifid_rs2),
    .idex_rd    (idex_rd),
    .idex_memrd (idex_memrd),
    .stall      (stall),
    .bubble     (bubble)
  );

  hz_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .wen    (memwb_regwr),
    .waddr  (memwb_rd),
    .wdata  (memwb_data),
    .raddr1 (ifid_rs1),
    .raddr2 (ifid_rs2),
    .rdata1 (rf_rdata1),
    .rdata2 (rf_rdata2)
  );
endmodule

// File: rtl/hz_checker.sv
module hz_checker #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   ifid_rs1,
  input logic [AW-1:0]   idex_rs1,
  input logic [AW-1:0]   exmem_rd,
  input logic            exmem_regwr,
  input logic            exmem_memrd,
  input logic [AW-1:0]   memwb_rd,
  input logic            memwb_regwr,
  input logic [XLEN-1:0] memwb_data,
  input logic [1:0]      fwd_a,
  input logic            idex_memrd,
  input logic            stall,
  input logic            bubble,
  input logic [XLEN-1:0] rf_rdata1
);
  // R3: both stages qualify -> younger wins
  a_r3_exmem_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (exmem_regwr && !exmem_memrd && exmem_rd != '0 && exmem_rd == idex_rs1 &&
     memwb_regwr && memwb_rd == idex_rs1) |-> fwd_a == 2'b10);

  // R2: a MEM/WB select needs a qualifying MEM/WB producer
  a_r2_memwb_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_a == 2'b01 |-> (memwb_regwr && memwb_rd == idex_rs1 && memwb_rd != '0));

  // R5: a load in EX/MEM never feeds the operand
  a_r5_no_load_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    exmem_memrd |-> fwd_a != 2'b10);

  // R6: stall comes with a bubble and only behind a load
  a_r6_stall_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (bubble && idex_memrd));

  // R8: a stored value reads back one cycle later when no new write intervenes
  a_r8_write_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (memwb_regwr && memwb_rd != '0) |=>
      ((ifid_rs1 == $past(memwb_rd) && !memwb_regwr) -> rf_rdata1 == $past(memwb_data)));

  // R10: register 0 reads zero
  a_r10_zero_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_rs1 == '0 |-> rf_rdata1 == '0);
endmodule

bind fwd_hazard_top hz_checker #(.XLEN(XLEN), .NREG(NREG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ifid_rs1    (ifid_rs1),
  .idex_rs1    (idex_rs1),
  .exmem_rd    (exmem_rd),
  .exmem_regwr (exmem_regwr),
  .exmem_memrd (exmem_memrd),
  .memwb_rd    (memwb_rd),
  .memwb_regwr (memwb_regwr),
  .memwb_data  (memwb_data),
  .fwd_a       (fwd_a),
  .idex_memrd  (idex_memrd),
  .stall       (stall),
  .bubble      (bubble),
  .rf_rdata1   (rf_rdata1)
);

// File: tb/sim_fwd_hazard_top.sv
module sim_fwd_hazard_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  ifid_rs1, ifid_rs2, idex_rs1, idex_rs2, idex_rd, exmem_rd, memwb_rd;
  logic        idex_memrd, exmem_regwr, exmem_memrd, memwb_regwr;
  logic [31:0] memwb_data;
  logic [1:0]  fwd_a, fwd_b;
  logic        stall, bubble;
  logic [31:0] rf_rdata1, rf_rdata2;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  fwd_hazard_top u0 (
    .clk(clk), .rst_n(rst_n),
    .ifid_rs1(ifid_rs1), .ifid_rs2(ifid_rs2),
    .idex_rs1(idex_rs1), .idex_rs2(idex_rs2), .idex_rd(idex_rd), .idex_memrd(idex_memrd),
    .exmem_rd(exmem_rd), .exmem_regwr(exmem_regwr), .exmem_memrd(exmem_memrd),
    .memwb_rd(memwb_rd), .memwb_regwr(memwb_regwr), .memwb_data(memwb_data),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .bubble(bubble),
    .rf_rdata1(rf_rdata1), .rf_rdata2(rf_rdata2)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    ifid_rs1 = 0; ifid_rs2 = 0; idex_rs1 = 0; idex_rs2 = 0; idex_rd = 0; idex_memrd = 0;
    exmem_rd = 0; exmem_regwr = 0; exmem_memrd = 0;
    memwb_rd = 0; memwb_regwr = 0; memwb_data = 0;
  endtask

  // write one register through the write-back port, returning at a negedge
  task automatic rf_write(input logic [4:0] r, input logic [31:0] d);
    @(negedge clk);
    memwb_rd = r; memwb_regwr = 1; memwb_data = d;
    @(negedge clk);
    memwb_regwr = 0; memwb_rd = 0;
  endtask

  task automatic t_reset();
    idle(); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    ifid_rs1 = 5'd7; ifid_rs2 = 5'd31; #1;
    check("R11", "reset reg7", rf_rdata1, 0);
    check("R11", "reset reg31", rf_rdata2, 0);
    check("R4", "reset fwd_a", fwd_a, 2'b00);
    check("R7", "reset stall", stall, 0);
  endtask

  task automatic t_exmem_fwd();
    idle(); idex_rs1 = 5'd3; idex_rs2 = 5'd9; exmem_rd = 5'd9; exmem_regwr = 1; #1;
    check("R1", "ex/mem to operand b", fwd_b, 2'b10);
    check("R4", "unrelated operand a", fwd_a, 2'b00);
    idex_rs1 = 5'd9; #1;
    check("R1", "ex/mem to both a", fwd_a, 2'b10);
  endtask

  task automatic t_memwb_fwd();
    idle(); idex_rs1 = 5'd12; idex_rs2 = 5'd4; memwb_rd = 5'd12; memwb_regwr = 1; #1;
    check("R2", "mem/wb to operand a", fwd_a, 2'b01);
    check("R2", "operand b untouched", fwd_b, 2'b00);
  endtask

  task automatic t_priority();
    idle(); idex_rs1 = 5'd6; idex_rs2 = 5'd6;
    exmem_rd = 5'd6; exmem_regwr = 1; memwb_rd = 5'd6; memwb_regwr = 1; #1;
    check("R3", "younger wins a", fwd_a, 2'b10);
    check("R3", "younger wins b", fwd_b, 2'b10);
    exmem_regwr = 0; #1;
    check("R4", "ex/mem write flag clear falls to mem/wb", fwd_a, 2'b01);
  endtask

  task automatic t_no_fwd();
    idle(); idex_rs1 = 5'd0; idex_rs2 = 5'd0; exmem_rd = 0; exmem_regwr = 1;
    memwb_rd = 0; memwb_regwr = 1; #1;
    check("R4", "register 0 never forwarded a", fwd_a, 2'b00);
    check("R4", "register 0 never forwarded b", fwd_b, 2'b00);
    idle(); idex_rs1 = 5'd8; exmem_rd = 5'd8; memwb_rd = 5'd8; #1;
    check("R4", "write flags clear", fwd_a, 2'b00);
  endtask

  task automatic t_load_no_exmem();
    idle(); idex_rs1 = 5'd5; exmem_rd = 5'd5; exmem_regwr = 1; exmem_memrd = 1; #1;
    check("R5", "load in ex/mem not forwarded", fwd_a, 2'b00);
    memwb_rd = 5'd5; memwb_regwr = 1; #1;
    check("R5", "falls back to mem/wb", fwd_a, 2'b01);
  endtask

  // load r5 in ID/EX, dependent reader of r5 in IF/ID, then advance by hand
  task automatic t_loaduse();
    idle(); idex_rd = 5'd5; idex_memrd = 1; ifid_rs1 = 5'd1; ifid_rs2 = 5'd5; #1;
    check("R6", "stall on load-use via rs2", stall, 1);
    check("R6", "bubble on load-use", bubble, 1);
    // bubble cycle: nop in ID/EX, load in EX/MEM, reader held in IF/ID
    idle(); ifid_rs1 = 5'd1; ifid_rs2 = 5'd5;
    exmem_rd = 5'd5; exmem_regwr = 1; exmem_memrd = 1; #1;
    check("R7", "single stall cycle only", stall, 0);
    // reader in ID/EX, nop in EX/MEM, load in MEM/WB
    idle(); idex_rs2 = 5'd5; memwb_rd = 5'd5; memwb_regwr = 1; #1;
    check("R7", "loaded value via mem/wb", fwd_b, 2'b01);
  endtask

  task automatic t_no_stall();
    idle(); idex_rd = 5'd5; idex_memrd = 0; ifid_rs1 = 5'd5; #1;
    check("R7", "alu producer no stall", stall, 0);
    idex_memrd = 1; ifid_rs1 = 5'd6; ifid_rs2 = 5'd7; #1;
    check("R7", "independent load no stall", stall, 0);
    idex_rd = 5'd0; ifid_rs1 = 5'd0; #1;
    check("R7", "load to register 0 no stall", bubble, 0);
  endtask

  task automatic t_rf();
    idle();
    rf_write(5'd10, 32'hCAFE_0010);
    rf_write(5'd11, 32'h1234_5678);
    ifid_rs1 = 5'd10; ifid_rs2 = 5'd11; #1;
    check("R8", "readback r10", rf_rdata1, 32'hCAFE_0010);
    check("R8", "readback r11", rf_rdata2, 32'h1234_5678);
    // same-cycle write and read of r10
    memwb_rd = 5'd10; memwb_regwr = 1; memwb_data = 32'hBEEF_0001; #1;
    check("R9", "same-cycle bypass", rf_rdata1, 32'hBEEF_0001);
    check("R9", "other port unaffected", rf_rdata2, 32'h1234_5678);
    @(negedge clk); memwb_regwr = 0; #1;
    check("R8", "bypassed value stored", rf_rdata1, 32'hBEEF_0001);
  endtask

  task automatic t_zero_reg();
    idle();
    rf_write(5'd0, 32'hFFFF_FFFF);
    ifid_rs1 = 5'd0; #1;
    check("R10", "register 0 after write", rf_rdata1, 0);
    memwb_rd = 5'd0; memwb_regwr = 1; memwb_data = 32'hAAAA_5555; #1;
    check("R10", "register 0 no bypass", rf_rdata1, 0);
    memwb_regwr = 0;
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_exmem_fwd();
    t_memwb_fwd();
    t_priority();
    t_no_fwd();
    t_load_no_exmem();
    t_loaduse();
    t_no_stall();
    t_rf();
    t_zero_reg();
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule